// File: doc/BRIEF.md
# Register Write Protection Unit

This unit sits between a simple synchronous bus slave port and an external, byte-addressable array of functional registers. It can forbid writes to any single byte of that array. Each protected byte has its own lock bit. Software sets and clears these bits through a bank of lock registers, and each lock register covers four neighbouring bytes.

The bus sees three address windows. The direct window passes reads and writes straight to the register array. The mirror window maps onto the same bytes. A write through the mirror window stores the data and also locks the byte it wrote. The lock window holds the lock registers. A write to a lock register changes only the lock bits whose write-enable bit is set in that same write. Only supervisor writes can change a lock register.

A write to a locked byte is dropped without any sign to the bus. Reads of every protected byte are always served in both windows. The unit does not contain the register array. It drives the array's address, data and write strobe, and it returns the array's read data to the bus.

Top module: `reg_wprot_unit`

## Requirements
- R1: A bus write at an address below NUM_BYTES raises reg_we_o combinationally in the same cycle, with reg_addr_o equal to the address and reg_wdata_o equal to bus_wdata_i, provided the byte is unlocked. A read at such an address returns reg_rdata_i on bus_rdata_o.
- R2: The mirror window covers MIRROR_BASE to MIRROR_BASE+NUM_BYTES-1 and reaches byte (address - MIRROR_BASE). A read returns that byte. A write stores the byte if it is unlocked and sets that byte's lock bit at the clock edge, in either privilege mode.
- R3: Lock register n sits at address LOCK_BASE+n, for n below NUM_BYTES/4. On a supervisor write, for each m in 0..3: if bus_wdata_i[m] is 1, lock bit m takes the value of bus_wdata_i[4+m]. If bus_wdata_i[m] is 0, lock bit m keeps its value.
- R4: Lock bit m of lock register n guards byte 4n+m. While that bit is 1, no write to the byte through either window raises reg_we_o. While it is 0, the byte can be written.
- R5: Reading lock register n returns lock bit m on bus_rdata_o[4+m] and zero on bus_rdata_o[3:0].
- R6: A lock register write with bus_sup_i low changes no lock bit. Reads of lock registers work in both modes.
- R7: While reset is applied, every lock bit is 0, and reset clears all lock bits.
- R8: A mirror write to a byte that is already locked does not raise reg_we_o, and the lock bit stays 1.
- R9: An access outside the three windows raises no reg_we_o, changes no lock bit and reads as 0x00.
- R10: A locked byte still reads back its current content through both windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_sup_i | input | 1 | Supervisor mode flag |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| reg_addr_o | output | OFF_W | Byte offset into the register array |
| reg_we_o | output | 1 | Register array write strobe |
| reg_wdata_o | output | 8 | Register array write data |
| reg_rdata_i | input | 8 | Register array read data at reg_addr_o |

## Verification
Lock register writes use enable masks that differ from their value nibbles. This shows whether only the enabled bits are updated. Separate cases set a bit and clear a bit. Writes to a locked byte and to its unlocked neighbour in the same lock register catch any mistake in which bit guards which byte. The same byte is then written through the direct window, through the mirror window, in user mode and in supervisor mode, which separates the four paths. Finally, every byte is locked, then unlocked, and then every other byte is locked through the mirror window. Address probes just past each window's end check the window boundaries.

// File: rtl/reg_wprot_pkg.sv
package reg_wprot_pkg;

  // Address window hit by a bus access
  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_DIRECT = 2'd1,
    WIN_MIRROR = 2'd2,
    WIN_LOCK   = 2'd3
  } win_e;

  // Bytes guarded by one lock register
  localparam int unsigned LOCKS_PER_REG = 4;

endpackage

// File: rtl/reg_wprot_decode.sv
module reg_wprot_decode
  import reg_wprot_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned NUM_BYTES   = 6144,
  parameter int unsigned MIRROR_BASE = 'h2000,
  parameter int unsigned LOCK_BASE   = 'h3800,
  parameter int unsigned OFF_W       = $clog2(NUM_BYTES),
  parameter int unsigned LIDX_W      = $clog2(NUM_BYTES / LOCKS_PER_REG)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [LIDX_W-1:0] lidx_o
);

  localparam int unsigned NUM_LOCK = NUM_BYTES / LOCKS_PER_REG;

  logic [31:0] a32;
  logic [31:0] mir_rel;
  logic [31:0] lock_rel;

  always_comb begin
    a32      = 32'(addr_i);
    mir_rel  = a32 - 32'(MIRROR_BASE);
    lock_rel = a32 - 32'(LOCK_BASE);
    win_o    = WIN_NONE;
    off_o    = '0;
    lidx_o   = '0;
    if (a32 < 32'(NUM_BYTES)) begin
      win_o = WIN_DIRECT;
      off_o = OFF_W'(a32);
    end else if ((a32 >= 32'(MIRROR_BASE)) && (mir_rel < 32'(NUM_BYTES))) begin
      win_o = WIN_MIRROR;
      off_o = OFF_W'(mir_rel);
    end else if ((a32 >= 32'(LOCK_BASE)) && (lock_rel < 32'(NUM_LOCK))) begin
      win_o  = WIN_LOCK;
      lidx_o = LIDX_W'(lock_rel);
    end
  end

endmodule

// File: rtl/reg_wprot_lock_bank.sv
module reg_wprot_lock_bank
  import reg_wprot_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6144,
  parameter int unsigned OFF_W     = $clog2(NUM_BYTES),
  parameter int unsigned LIDX_W    = $clog2(NUM_BYTES / LOCKS_PER_REG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lk_wr_req_i,
  input  logic                     sup_i,
  input  logic [LIDX_W-1:0]        lk_idx_i,
  input  logic [7:0]               wdata_i,
  input  logic                     mir_set_i,
  input  logic [OFF_W-1:0]         byte_idx_i,
  output logic [LOCKS_PER_REG-1:0] lk_rdata_o,
  output logic                     byte_locked_o
);

  localparam int unsigned NUM_LOCK = NUM_BYTES / LOCKS_PER_REG;

  logic [LOCKS_PER_REG-1:0] slb_q [NUM_LOCK];

  logic                     upd_en;
  logic [LIDX_W-1:0]        upd_idx;
  logic [LOCKS_PER_REG-1:0] upd_val;
  logic [LOCKS_PER_REG-1:0] lk_cur;
  logic [LOCKS_PER_REG-1:0] lk_merged;
  logic [LIDX_W-1:0]        byte_reg;
  logic [1:0]               byte_pos;
  logic [LOCKS_PER_REG-1:0] byte_nib;

  assign byte_reg = byte_idx_i[OFF_W-1:2];
  assign byte_pos = byte_idx_i[1:0];

  // Read ports, guarded against out-of-range indices
  always_comb begin
    lk_cur   = (32'(lk_idx_i) < 32'(NUM_LOCK)) ? slb_q[lk_idx_i] : '0;
    byte_nib = (32'(byte_reg) < 32'(NUM_LOCK)) ? slb_q[byte_reg] : '0;
  end

  assign lk_rdata_o    = lk_cur;
  assign byte_locked_o = byte_nib[byte_pos];

  // Per-bit merge under the write-enable mask
  for (genvar m = 0; m < LOCKS_PER_REG; m++) begin : g_merge
    assign lk_merged[m] = wdata_i[m] ? wdata_i[LOCKS_PER_REG+m] : lk_cur[m];
  end

  // Next-state: at most one lock register changes per cycle
  always_comb begin
    upd_en  = 1'b0;
    upd_idx = lk_idx_i;
    upd_val = lk_cur;
    if (lk_wr_req_i && sup_i) begin
      upd_en  = 1'b1;
      upd_val = lk_merged;
    end else if (mir_set_i) begin
      upd_en  = 1'b1;
      upd_idx = byte_reg;
      upd_val = byte_nib | (LOCKS_PER_REG'(1) << byte_pos);
    end
  end

  // Register: clock enable upd_en
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_LOCK); i++) begin
        slb_q[i] <= '0;
      end
    end else if (upd_en) begin
      slb_q[upd_idx] <= upd_val;
    end
  end

  // R6: user-mode lock writes leave the addressed lock register untouched
  assert_user_no_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_wr_req_i && !sup_i) |=> (slb_q[$past(lk_idx_i)] == $past(lk_cur)));

  // R2: a mirror write leaves the byte's lock bit set afterwards
  assert_mirror_sets_lock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mir_set_i |=> slb_q[$past(byte_reg)][$past(byte_pos)]);

  for (genvar m = 0; m < LOCKS_PER_REG; m++) begin : g_chk
    // R3: a disabled bit keeps its value
    assert_masked_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_wr_req_i && sup_i && !wdata_i[m]) |=>
        (slb_q[$past(lk_idx_i)][m] == $past(lk_cur[m])));
    // R3: an enabled bit takes the written value
    assert_enabled_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_wr_req_i && sup_i && wdata_i[m]) |=>
        (slb_q[$past(lk_idx_i)][m] == $past(wdata_i[LOCKS_PER_REG+m])));
  end

endmodule

// File: rtl/reg_wprot_access.sv
module reg_wprot_access
  import reg_wprot_pkg::*;
#(
  parameter int unsigned OFF_W = 13
) (
  input  logic                     bus_valid_i,
  input  logic                     bus_write_i,
  input  logic [7:0]               bus_wdata_i,
  input  win_e                     win_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic                     byte_locked_i,
  input  logic [LOCKS_PER_REG-1:0] lk_rdata_i,
  input  logic [7:0]               reg_rdata_i,
  output logic [OFF_W-1:0]         reg_addr_o,
  output logic                     reg_we_o,
  output logic [7:0]               reg_wdata_o,
  output logic [7:0]               bus_rdata_o,
  output logic                     mir_set_o,
  output logic                     lk_wr_req_o
);

  logic wr;
  logic rd;
  logic data_win;

  always_comb begin
    wr          = bus_valid_i && bus_write_i;
    rd          = bus_valid_i && !bus_write_i;
    data_win    = (win_i == WIN_DIRECT) || (win_i == WIN_MIRROR);
    reg_addr_o  = off_i;
    reg_wdata_o = bus_wdata_i;
    reg_we_o    = wr && data_win && !byte_locked_i;
    mir_set_o   = wr && (win_i == WIN_MIRROR);
    lk_wr_req_o = wr && (win_i == WIN_LOCK);
    bus_rdata_o = 8'h00;
    if (rd) begin
      if (data_win) begin
        bus_rdata_o = reg_rdata_i;
      end else if (win_i == WIN_LOCK) begin
        bus_rdata_o = {lk_rdata_i, 4'b0000};
      end
    end
  end

endmodule

// File: rtl/reg_wprot_unit.sv
module reg_wprot_unit
  import reg_wprot_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned NUM_BYTES   = 6144,
  parameter int unsigned MIRROR_BASE = 'h2000,
  parameter int unsigned LOCK_BASE   = 'h3800,
  localparam int unsigned OFF_W      = $clog2(NUM_BYTES),
  localparam int unsigned LIDX_W     = $clog2(NUM_BYTES / LOCKS_PER_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic              bus_sup_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [OFF_W-1:0]  reg_addr_o,
  output logic              reg_we_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i
);

  // Reset synchronizer: asserts at once, releases after two edges
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_d;
  logic       rst_sync_n;

  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  win_e                     win;
  logic [OFF_W-1:0]         off;
  logic [LIDX_W-1:0]        lidx;
  logic                     byte_locked;
  logic [LOCKS_PER_REG-1:0] lk_rdata;
  logic                     mir_set;
  logic                     lk_wr_req;

  reg_wprot_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_BYTES   (NUM_BYTES),
    .MIRROR_BASE (MIRROR_BASE),
    .LOCK_BASE   (LOCK_BASE),
    .OFF_W       (OFF_W),
    .LIDX_W      (LIDX_W)
  ) decode_i (
    .addr_i (bus_addr_i),
    .win_o  (win),
    .off_o  (off),
    .lidx_o (lidx)
  );

  reg_wprot_lock_bank #(
    .NUM_BYTES (NUM_BYTES),
    .OFF_W     (OFF_W),
    .LIDX_W    (LIDX_W)
  ) bank_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .lk_wr_req_i   (lk_wr_req),
    .sup_i         (bus_sup_i),
    .lk_idx_i      (lidx),
    .wdata_i       (bus_wdata_i),
    .mir_set_i     (mir_set),
    .byte_idx_i    (off),
    .lk_rdata_o    (lk_rdata),
    .byte_locked_o (byte_locked)
  );

  reg_wprot_access #(
    .OFF_W (OFF_W)
  ) access_i (
    .bus_valid_i   (bus_valid_i),
    .bus_write_i   (bus_write_i),
    .bus_wdata_i   (bus_wdata_i),
    .win_i         (win),
    .off_i         (off),
    .byte_locked_i (byte_locked),
    .lk_rdata_i    (lk_rdata),
    .reg_rdata_i   (reg_rdata_i),
    .reg_addr_o    (reg_addr_o),
    .reg_we_o      (reg_we_o),
    .reg_wdata_o   (reg_wdata_o),
    .bus_rdata_o   (bus_rdata_o),
    .mir_set_o     (mir_set),
    .lk_wr_req_o   (lk_wr_req)
  );

  // R9: the array strobe only fires for addresses inside a data window
  assert_strobe_in_window_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    reg_we_o |-> ((32'(bus_addr_i) < 32'(NUM_BYTES)) ||
                  ((32'(bus_addr_i) >= 32'(MIRROR_BASE)) &&
                   (32'(bus_addr_i) < 32'(MIRROR_BASE + NUM_BYTES)))));

  // R4: no array write while the guarding lock bit is set
  assert_locked_no_we_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    reg_we_o |-> !byte_locked);

  // R1: direct-window accesses address the same byte and carry the bus data
  assert_direct_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_valid_i && (32'(bus_addr_i) < 32'(NUM_BYTES))) |->
      ((32'(reg_addr_o) == 32'(bus_addr_i)) && (reg_wdata_o == bus_wdata_i)));

endmodule

// File: tb/reg_wprot_unit_tb_top.sv
module reg_wprot_unit_tb_top;

  localparam int unsigned NB     = 32;
  localparam int unsigned NL     = NB / 4;
  localparam int unsigned ADDR_W = 14;
  localparam int unsigned OFF_W  = $clog2(NB);

  logic              clk;
  logic              rst_n;
  logic              bus_valid;
  logic              bus_write;
  logic              bus_sup;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata;
  logic [7:0]        bus_rdata;
  logic [OFF_W-1:0]  reg_addr;
  logic              reg_we;
  logic [7:0]        reg_wdata;
  logic [7:0]        reg_rdata;

  reg_wprot_unit #(.ADDR_W(ADDR_W), .NUM_BYTES(NB)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_valid_i (bus_valid),
    .bus_write_i (bus_write),
    .bus_sup_i   (bus_sup),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .reg_addr_o  (reg_addr),
    .reg_we_o    (reg_we),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // External register array model
  logic [7:0] mem [NB];
  initial for (int i = 0; i < int'(NB); i++) mem[i] = 8'h00;
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
  assign reg_rdata = mem[reg_addr];

  logic [7:0] exp_mem [NB];
  int n_chk;
  int n_fail;
  logic done;
  logic last_we;
  logic [7:0] rd_val;

  typedef struct packed {
    logic        wr;
    logic        sup;
    logic [13:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;   // write: expected reg_we; read: expected data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 14'h0005, 8'hA5, 8'h01, 4'd1},  // R1 direct write
    '{1'b0, 1'b0, 14'h0005, 8'h00, 8'hA5, 4'd1},  // R1 direct read
    '{1'b1, 1'b1, 14'h3801, 8'hF2, 8'h00, 4'd3},  // R3 enable only bit 1
    '{1'b0, 1'b0, 14'h3801, 8'h00, 8'h20, 4'd5},  // R5 readback
    '{1'b1, 1'b1, 14'h0005, 8'h3C, 8'h00, 4'd4},  // R4 locked byte
    '{1'b0, 1'b0, 14'h0005, 8'h00, 8'hA5, 4'd10}, // R10 content kept
    '{1'b1, 1'b0, 14'h0004, 8'h11, 8'h01, 4'd4},  // R4 neighbour open
    '{1'b0, 1'b1, 14'h0004, 8'h00, 8'h11, 4'd1},
    '{1'b1, 1'b0, 14'h3801, 8'hFF, 8'h00, 4'd6},  // R6 user write
    '{1'b0, 1'b0, 14'h3801, 8'h00, 8'h20, 4'd6},
    '{1'b1, 1'b0, 14'h2007, 8'h77, 8'h01, 4'd2},  // R2 mirror write
    '{1'b0, 1'b0, 14'h2007, 8'h00, 8'h77, 4'd2},
    '{1'b0, 1'b1, 14'h3801, 8'h00, 8'hA0, 4'd2},  // R2 lock set
    '{1'b1, 1'b1, 14'h2005, 8'h99, 8'h00, 4'd8},  // R8 mirror to locked
    '{1'b0, 1'b0, 14'h0005, 8'h00, 8'hA5, 4'd8},
    '{1'b0, 1'b1, 14'h3801, 8'h00, 8'hA0, 4'd8},
    '{1'b1, 1'b1, 14'h3801, 8'h02, 8'h00, 4'd3},  // R3 clear bit 1 only
    '{1'b0, 1'b1, 14'h3801, 8'h00, 8'h80, 4'd3},
    '{1'b1, 1'b1, 14'h0005, 8'h3C, 8'h01, 4'd4},  // R4 unlocked again
    '{1'b0, 1'b0, 14'h2005, 8'h00, 8'h3C, 4'd2}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic s, input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_sup = s; bus_addr = a; bus_wdata = d;
    #1 last_we = reg_we;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_rd(input logic s, input logic [13:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_sup = s; bus_addr = a;
    #1 rd_val = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; last_we = 1'b0; rd_val = '0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_sup = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < int'(NB); i++) exp_mem[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: all lock registers read zero after reset
    for (int n = 0; n < int'(NL); n++) begin
      do_rd(1'b0, 14'h3800 + 14'(n));
      chk("R7 reset lock", rd_val, 8'h00);
    end

    // R9: addresses just past each window
    do_rd(1'b1, 14'h0020);          chk("R9 read past direct", rd_val, 8'h00);
    do_wr(1'b1, 14'h0020, 8'hEE);   chk("R9 write past direct", 8'(last_we), 8'h00);
    do_wr(1'b1, 14'h2020, 8'hEE);   chk("R9 write past mirror", 8'(last_we), 8'h00);
    do_wr(1'b1, 14'h3808, 8'hFF);   chk("R9 write past lock", 8'(last_we), 8'h00);
    do_rd(1'b1, 14'h3808);          chk("R9 read past lock", rd_val, 8'h00);
    for (int n = 0; n < int'(NL); n++) begin
      do_rd(1'b1, 14'h3800 + 14'(n));
      chk("R9 locks unchanged", rd_val, 8'h00);
    end

    // Vector table
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) begin
        do_wr(VECS[v].sup, VECS[v].addr, VECS[v].data);
        if (last_we !== VECS[v].exp[0]) begin
          n_fail++;
          $display("FAIL R%0d vec %0d reg_we actual=%0d expected=%0d",
                   VECS[v].req, v, last_we, VECS[v].exp[0]);
        end
        n_chk++;
        if (VECS[v].exp[0]) exp_mem[VECS[v].addr[4:0]] = VECS[v].data;
      end else begin
        do_rd(VECS[v].sup, VECS[v].addr);
        if (rd_val !== VECS[v].exp) begin
          n_fail++;
          $display("FAIL R%0d vec %0d rdata actual=%02h expected=%02h",
                   VECS[v].req, v, rd_val, VECS[v].exp);
        end
        n_chk++;
      end
    end

    // R3 / R4 / R8 / R10: lock everything, then try every byte
    for (int n = 0; n < int'(NL); n++) begin
      do_wr(1'b1, 14'h3800 + 14'(n), 8'hFF);
      do_rd(1'b0, 14'h3800 + 14'(n));
      chk("R3 lock all", rd_val, 8'hF0);
    end
    for (int b = 0; b < int'(NB); b++) begin
      do_wr(1'b1, 14'(b), 8'hC3);
      chk("R4 direct locked", 8'(last_we), 8'h00);
      do_wr(1'b0, 14'h2000 + 14'(b), 8'hC3);
      chk("R8 mirror locked", 8'(last_we), 8'h00);
      do_rd(1'b0, 14'h2000 + 14'(b));
      chk("R10 locked read", rd_val, exp_mem[b]);
    end

    // R3 / R1: unlock all, write every byte, read back
    for (int n = 0; n < int'(NL); n++) begin
      do_wr(1'b1, 14'h3800 + 14'(n), 8'h0F);
      do_rd(1'b1, 14'h3800 + 14'(n));
      chk("R3 unlock all", rd_val, 8'h00);
    end
    for (int b = 0; b < int'(NB); b++) begin
      do_wr(1'b0, 14'(b), 8'(b) ^ 8'h5A);
      chk("R1 write open", 8'(last_we), 8'h01);
      exp_mem[b] = 8'(b) ^ 8'h5A;
      do_rd(1'b0, 14'(b));
      chk("R1 readback", rd_val, exp_mem[b]);
    end

    // R2 / R4: mirror-lock even bytes
    for (int b = 0; b < int'(NB); b += 2) begin
      do_wr(1'b0, 14'h2000 + 14'(b), 8'hE0 + 8'(b));
      chk("R2 mirror write", 8'(last_we), 8'h01);
      exp_mem[b] = 8'hE0 + 8'(b);
    end
    for (int n = 0; n < int'(NL); n++) begin
      do_rd(1'b0, 14'h3800 + 14'(n));
      chk("R2 even locks", rd_val, 8'h50);
    end
    for (int b = 0; b < int'(NB); b++) begin
      do_wr(1'b1, 14'(b), 8'h3D);
      chk("R4 even locked odd open", 8'(last_we), (b % 2 == 0) ? 8'h00 : 8'h01);
      if (b % 2 == 1) exp_mem[b] = 8'h3D;
      do_rd(1'b1, 14'(b));
      chk("R10 content", rd_val, exp_mem[b]);
    end

    // R7: reset in mid-run clears locks
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int n = 0; n < int'(NL); n++) begin
      do_rd(1'b0, 14'h3800 + 14'(n));
      chk("R7 reset clears", rd_val, 8'h00);
    end
    do_wr(1'b1, 14'h0000, 8'h42);
    chk("R7 byte open after reset", 8'(last_we), 8'h01);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule